// File: doc/BRIEF.md
# Dual Watermark FIFO Buffer

This block holds two first-in first-out queues of 16 entries of 32 bits each. One carries data from a host register port (CPU or DMA) towards a serial shift engine. The other carries data back from the shift engine to the host. Each queue keeps its own read pointer, write pointer and occupancy count. The serial side is a pair of plain strobes: a pop on the transmit queue and a push on the receive queue.

Two level requests go to an interrupt or DMA controller. The transmit request rises when enough of the transmit queue is free. The receive request rises when enough of the receive queue is filled. Each queue has its own 3-bit threshold code, set independently of the other. Both requests are recomputed every cycle from the current counts.

A host access of any size moves a queue by exactly one whole entry. The host cannot drop an entry on a full transmit queue or take one from an empty receive queue without being told: either mistake raises a sticky flag, which the host clears by strobing a 1.

Top module: `sfw_wm_pair`

## Requirements
- R1: Each queue stores up to 16 entries of 32 bits, delivers them in the order written, and never reports more than 16 entries.
- R2: A host transmit write moves the transmit count by exactly one entry in one cycle whatever the access size. Size code 00 (byte) stores the value zero-extended from bits 7:0, code 01 (halfword) zero-extends bits 15:0, and codes 10 and 11 store all 32 bits.
- R3: With transmit code 000, the transmit request is high only when all 16 entries are free. With code 100, it is high when 12 or more entries are free.
- R4: With transmit code 101, the transmit request is high when 8 or more entries are free. With code 110, it needs 4 or more free, and with code 111 it needs 1 or more free.
- R5: The receive request is high when the filled count is at least the level for its code: 1 for code 000, 4 for 100, 8 for 101, 12 for 110, and 16 for 111.
- R6: The codes 001, 010 and 011 behave exactly like code 000, for both requests.
- R7: A host write to a full transmit queue is dropped and does not change the stored contents or the count. It sets the overflow flag, which stays set until a cycle with the overflow-clear strobe high and no new overflow. If a new overflow and a clear happen in the same cycle, the flag stays set.
- R8: A host read of an empty receive queue is dropped and sets the sticky underflow flag, which has a clear strobe of its own. While the receive queue is empty, the host read data is zero.
- R9: Both requests follow the counts in the same cycle. A request changes in the very cycle after the clock edge that changes its count, with no extra register stage.
- R10: A synchronous reset empties both queues and clears both flags. Both requests are held low for every cycle in which reset is high.
- R11: A serial pop from an empty transmit queue and a serial push into a full receive queue are dropped. Neither one changes the count or the contents, and neither raises a flag.
- R12: A transmit write and a serial pop in the same cycle, on a queue that is neither empty nor full, leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_wm_code | input | 3 | Transmit threshold code |
| rx_wm_code | input | 3 | Receive threshold code |
| host_tx_wr | input | 1 | Host write strobe into the transmit queue |
| host_tx_size | input | 2 | Host write access size (00 byte, 01 halfword, 1x word) |
| host_tx_wdata | input | 32 | Host write data |
| host_rx_rd | input | 1 | Host read strobe from the receive queue |
| host_rx_rdata | output | 32 | Oldest receive entry, zero when empty |
| ser_tx_pop | input | 1 | Serial side takes one transmit entry |
| ser_tx_data | output | 32 | Oldest transmit entry, zero when empty |
| ser_rx_push | input | 1 | Serial side adds one receive entry |
| ser_rx_data | input | 32 | Receive data from the serial side |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| unf_clr | input | 1 | Write-1 clear of the underflow flag |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_level | output | 5 | Receive queue occupancy |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |
| ovf_flag | output | 1 | Sticky transmit overflow flag |
| unf_flag | output | 1 | Sticky receive underflow flag |

## Verification
Every threshold code is tried by filling a queue one entry at a time from empty to full and checking the request after each step. This finds a level that is off by one and a comparison whose direction is wrong. It also shows whether the transmit side uses free space while the receive side uses filled entries. Reserved codes go through the same sweep and must give the same result as code 000.

Mixed-size writes, read back through the serial side, separate pointer movement from data width. Writes to a full queue and reads from an empty one are checked through the contents that come out later. This proves that dropped accesses touched nothing. Serial-side misuse must move no count and raise no flag, and a write in the same cycle as a pop must leave the count where it was.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

  localparam int SFW_DATA_W = 32;
  localparam int SFW_CODE_W = 3;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'b00,
    ACC_HALF  = 2'b01,
    ACC_WORD  = 2'b10,
    ACC_WORD2 = 2'b11
  } acc_size_e;

  // Entry level that a 3-bit code selects; reserved codes fall to the 000 level.
  function automatic int wm_threshold(input logic [SFW_CODE_W-1:0] code,
                                      input bit is_rx, input int depth);
    int lvl;
    if (is_rx) begin
      case (code)
        3'b100:  lvl = depth / 4;
        3'b101:  lvl = depth / 2;
        3'b110:  lvl = (depth * 3) / 4;
        3'b111:  lvl = depth;
        default: lvl = 1;
      endcase
    end else begin
      case (code)
        3'b100:  lvl = (depth * 3) / 4;
        3'b101:  lvl = depth / 2;
        3'b110:  lvl = depth / 4;
        3'b111:  lvl = 1;
        default: lvl = depth;
      endcase
    end
    return lvl;
  endfunction

  // Zero-extend narrow host writes into one whole entry.
  function automatic logic [SFW_DATA_W-1:0] fit_to_size(input logic [SFW_DATA_W-1:0] d,
                                                        input acc_size_e sz);
    logic [SFW_DATA_W-1:0] r;
    case (sz)
      ACC_BYTE: r = {{(SFW_DATA_W-8){1'b0}}, d[7:0]};
      ACC_HALF: r = {{(SFW_DATA_W-16){1'b0}}, d[15:0]};
      default:  r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sfw_ring.sv
module sfw_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/sfw_wm_req.sv
module sfw_wm_req #(
  parameter int DEPTH = 16,
  parameter bit IS_RX = 1'b0,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          rst,
  input  logic [2:0]    code,
  input  logic [CW-1:0] level,
  output logic          req
);
  import sfw_pkg::*;

  int   thr;
  logic hit;

  assign thr = wm_threshold(code, IS_RX, DEPTH);

  generate
    if (IS_RX) begin : g_filled
      assign hit = int'(level) >= thr;
    end else begin : g_free
      assign hit = (DEPTH - int'(level)) >= thr;
    end
  endgenerate

  assign req = hit && !rst;

endmodule

// File: rtl/sfw_flag.sv
module sfw_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/sfw_wm_pair.sv
module sfw_wm_pair #(
  parameter int DEPTH = 16,
  localparam int DW   = sfw_pkg::SFW_DATA_W,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    tx_wm_code,
  input  logic [2:0]    rx_wm_code,
  input  logic          host_tx_wr,
  input  logic [1:0]    host_tx_size,
  input  logic [DW-1:0] host_tx_wdata,
  input  logic          host_rx_rd,
  output logic [DW-1:0] host_rx_rdata,
  input  logic          ser_tx_pop,
  output logic [DW-1:0] ser_tx_data,
  input  logic          ser_rx_push,
  input  logic [DW-1:0] ser_rx_data,
  input  logic          ovf_clr,
  input  logic          unf_clr,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic          tx_req,
  output logic          rx_req,
  output logic          ovf_flag,
  output logic          unf_flag
);
  import sfw_pkg::*;

  // Named internal events, visible to the bound checker.
  logic          tx_full, tx_empty, tx_push_ok, tx_pop_ok;
  logic          rx_full, rx_empty, rx_push_ok, rx_pop_ok;
  logic          tx_overflow_ev, rx_underflow_ev;
  logic [DW-1:0] tx_entry;

  assign tx_entry = fit_to_size(host_tx_wdata, acc_size_e'(host_tx_size));

  sfw_ring #(.W(DW), .DEPTH(DEPTH)) u_tx_ring (
    .clk(clk), .rst(rst),
    .push(host_tx_wr), .push_data(tx_entry), .pop(ser_tx_pop),
    .head(ser_tx_data), .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  sfw_ring #(.W(DW), .DEPTH(DEPTH)) u_rx_ring (
    .clk(clk), .rst(rst),
    .push(ser_rx_push), .push_data(ser_rx_data), .pop(host_rx_rd),
    .head(host_rx_rdata), .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  sfw_wm_req #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_req (
    .rst(rst), .code(tx_wm_code), .level(tx_level), .req(tx_req)
  );

  sfw_wm_req #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_req (
    .rst(rst), .code(rx_wm_code), .level(rx_level), .req(rx_req)
  );

  assign tx_overflow_ev  = host_tx_wr && tx_full;
  assign rx_underflow_ev = host_rx_rd && rx_empty;

  sfw_flag u_ovf (.clk(clk), .rst(rst), .set(tx_overflow_ev),  .clr(ovf_clr), .flag(ovf_flag));
  sfw_flag u_unf (.clk(clk), .rst(rst), .set(rx_underflow_ev), .clr(unf_clr), .flag(unf_flag));

endmodule

// File: rtl/sfw_chk.sv
module sfw_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          host_tx_wr,
  input logic          host_rx_rd,
  input logic          ser_tx_pop,
  input logic          ser_rx_push,
  input logic          ovf_clr,
  input logic          unf_clr,
  input logic [2:0]    tx_wm_code,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          tx_req,
  input logic          rx_req,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic [31:0]   host_rx_rdata,
  input logic          tx_overflow_ev,
  input logic          rx_underflow_ev
);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

  p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
    (host_tx_wr && !ser_tx_pop && tx_level < CW'(DEPTH)) |=> (tx_level == $past(tx_level) + 1'b1));

  p_tx_code000_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_wm_code == 3'b000) |-> (tx_req == (tx_level == '0)));

  p_tx_code111_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_wm_code == 3'b111) |-> (tx_req == (tx_level != CW'(DEPTH))));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (host_tx_wr && !ser_tx_pop && tx_level == CW'(DEPTH)) |=> (tx_level == CW'(DEPTH) && ovf_flag));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_unf_set_r8: assert property (@(posedge clk) disable iff (rst)
    rx_underflow_ev |=> (unf_flag && rx_level == $past(rx_level) + CW'(ser_rx_push)));

  p_empty_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |-> (host_rx_rdata == '0));

  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (unf_flag && !unf_clr) |=> unf_flag);

  p_flag_source_r11: assert property (@(posedge clk) disable iff (rst)
    (!tx_overflow_ev && !ovf_flag) |=> !ovf_flag);

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (tx_level == '0 && rx_level == '0 && !ovf_flag && !unf_flag));

  p_reset_req_r10: assert property (@(posedge clk)
    rst |-> (!tx_req && !rx_req));

endmodule

bind sfw_wm_pair sfw_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .host_tx_wr(host_tx_wr), .host_rx_rd(host_rx_rd),
  .ser_tx_pop(ser_tx_pop), .ser_rx_push(ser_rx_push),
  .ovf_clr(ovf_clr), .unf_clr(unf_clr),
  .tx_wm_code(tx_wm_code),
  .tx_level(tx_level), .rx_level(rx_level),
  .tx_req(tx_req), .rx_req(rx_req),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag),
  .host_rx_rdata(host_rx_rdata),
  .tx_overflow_ev(tx_overflow_ev), .rx_underflow_ev(rx_underflow_ev)
);

// File: tb/sfw_wm_pair_tb.sv
module sfw_wm_pair_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  tx_wm_code = 3'b000, rx_wm_code = 3'b000;
  logic        host_tx_wr = 1'b0, host_rx_rd = 1'b0;
  logic [1:0]  host_tx_size = 2'b10;
  logic [31:0] host_tx_wdata = '0, ser_rx_data = '0;
  logic        ser_tx_pop = 1'b0, ser_rx_push = 1'b0;
  logic        ovf_clr = 1'b0, unf_clr = 1'b0;
  logic [31:0] host_rx_rdata, ser_tx_data;
  logic [4:0]  tx_level, rx_level;
  logic        tx_req, rx_req, ovf_flag, unf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sfw_wm_pair u_dut (
    .clk(clk), .rst(rst), .tx_wm_code(tx_wm_code), .rx_wm_code(rx_wm_code),
    .host_tx_wr(host_tx_wr), .host_tx_size(host_tx_size), .host_tx_wdata(host_tx_wdata),
    .host_rx_rd(host_rx_rd), .host_rx_rdata(host_rx_rdata),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
    .ovf_clr(ovf_clr), .unf_clr(unf_clr),
    .tx_level(tx_level), .rx_level(rx_level), .tx_req(tx_req), .rx_req(rx_req),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected requests restated from the requirement text.
  function automatic bit tx_exp(input logic [2:0] code, input int free);
    case (code)
      3'b100:  return free >= 12;
      3'b101:  return free >= 8;
      3'b110:  return free >= 4;
      3'b111:  return free >= 1;
      default: return free == 16;
    endcase
  endfunction

  function automatic bit rx_exp(input logic [2:0] code, input int used);
    case (code)
      3'b100:  return used >= 4;
      3'b101:  return used >= 8;
      3'b110:  return used >= 12;
      3'b111:  return used == 16;
      default: return used >= 1;
    endcase
  endfunction

  // Every driver starts and ends on a falling edge; one rising edge in between.
  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R10 tx_req low in reset", {31'b0, tx_req}, 32'd0);
    chk("R10 rx_req low in reset", {31'b0, rx_req}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic host_write(input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk); host_tx_wr = 1'b1; host_tx_wdata = d; host_tx_size = sz;
    @(negedge clk); host_tx_wr = 1'b0;
  endtask

  task automatic ser_push(input logic [31:0] d);
    @(negedge clk); ser_rx_push = 1'b1; ser_rx_data = d;
    @(negedge clk); ser_rx_push = 1'b0;
  endtask

  task automatic ser_pop();
    @(negedge clk); ser_tx_pop = 1'b1;
    @(negedge clk); ser_tx_pop = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); host_rx_rd = 1'b1;
    @(negedge clk); host_rx_rd = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); ovf_clr = 1'b1; unf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0; unf_clr = 1'b0;
  endtask

  task automatic t_reset_state();
    host_write(32'h1, 2'b10);
    ser_push(32'h2);
    do_reset();
    @(negedge clk);
    chk("R10 tx empty after reset", {27'b0, tx_level}, 32'd0);
    chk("R10 rx empty after reset", {27'b0, rx_level}, 32'd0);
    chk("R10 ovf clear", {31'b0, ovf_flag}, 32'd0);
    chk("R10 unf clear", {31'b0, unf_flag}, 32'd0);
  endtask

  task automatic t_order_sizes();
    do_reset();
    host_write(32'hAABBCCDD, 2'b00);
    chk("R2 byte write one entry", {27'b0, tx_level}, 32'd1);
    host_write(32'h11223344, 2'b01);
    chk("R2 half write one entry", {27'b0, tx_level}, 32'd2);
    host_write(32'hCAFEF00D, 2'b10);
    host_write(32'h0BADBEEF, 2'b11);
    chk("R2 word writes one entry each", {27'b0, tx_level}, 32'd4);
    chk("R2 byte zero-extended", ser_tx_data, 32'h000000DD);
    ser_pop();
    chk("R2 half zero-extended", ser_tx_data, 32'h00003344);
    ser_pop();
    chk("R1 word order", ser_tx_data, 32'hCAFEF00D);
    ser_pop();
    chk("R1 word order last", ser_tx_data, 32'h0BADBEEF);
    ser_pop();
    chk("R1 tx drained", {27'b0, tx_level}, 32'd0);
  endtask

  task automatic sweep_tx(input logic [2:0] code, input string req);
    tx_wm_code = code;
    do_reset();
    for (int n = 0; n <= 16; n++) begin
      @(negedge clk);
      chk(req, {31'b0, tx_req}, {31'b0, tx_exp(code, 16 - n)});
      if (n < 16) host_write(32'(n), 2'b10);
    end
  endtask

  task automatic sweep_rx(input logic [2:0] code, input string req);
    rx_wm_code = code;
    do_reset();
    for (int n = 0; n <= 16; n++) begin
      @(negedge clk);
      chk(req, {31'b0, rx_req}, {31'b0, rx_exp(code, n)});
      if (n < 16) ser_push(32'(n));
    end
  endtask

  task automatic t_tx_codes();
    sweep_tx(3'b000, "R3 tx code 000 R9");
    sweep_tx(3'b100, "R3 tx code 100 R9");
    sweep_tx(3'b101, "R4 tx code 101");
    sweep_tx(3'b110, "R4 tx code 110");
    sweep_tx(3'b111, "R4 tx code 111 R9");
  endtask

  task automatic t_rx_codes();
    sweep_rx(3'b000, "R5 rx code 000 R9");
    sweep_rx(3'b100, "R5 rx code 100");
    sweep_rx(3'b101, "R5 rx code 101");
    sweep_rx(3'b110, "R5 rx code 110");
    sweep_rx(3'b111, "R5 rx code 111");
  endtask

  task automatic t_reserved();
    sweep_tx(3'b001, "R6 tx code 001");
    sweep_tx(3'b010, "R6 tx code 010");
    sweep_tx(3'b011, "R6 tx code 011");
    sweep_rx(3'b001, "R6 rx code 001");
    sweep_rx(3'b011, "R6 rx code 011");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int n = 0; n < 16; n++) host_write(32'h100 + 32'(n), 2'b10);
    chk("R7 full before extra write", {31'b0, ovf_flag}, 32'd0);
    host_write(32'hDEAD0000, 2'b10);
    chk("R7 count stays 16", {27'b0, tx_level}, 32'd16);
    chk("R7 overflow set", {31'b0, ovf_flag}, 32'd1);
    // Clear strobe in the same cycle as another overflow: set wins.
    @(negedge clk); host_tx_wr = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); host_tx_wr = 1'b0; ovf_clr = 1'b0;
    chk("R7 set beats clear", {31'b0, ovf_flag}, 32'd1);
    for (int n = 0; n < 16; n++) begin
      chk("R7 contents untouched", ser_tx_data, 32'h100 + 32'(n));
      ser_pop();
    end
    chk("R7 flag sticky after drain", {31'b0, ovf_flag}, 32'd1);
    clear_flags();
    chk("R7 flag cleared by write-1", {31'b0, ovf_flag}, 32'd0);
  endtask

  task automatic t_underflow();
    do_reset();
    chk("R8 empty read data zero", host_rx_rdata, 32'd0);
    host_read();
    chk("R8 underflow set", {31'b0, unf_flag}, 32'd1);
    chk("R8 count stays 0", {27'b0, rx_level}, 32'd0);
    ser_push(32'h55AA55AA);
    chk("R8 later data intact", host_rx_rdata, 32'h55AA55AA);
    chk("R8 flag sticky", {31'b0, unf_flag}, 32'd1);
    host_read();
    chk("R8 rx empty again zero", host_rx_rdata, 32'd0);
    clear_flags();
    chk("R8 flag cleared", {31'b0, unf_flag}, 32'd0);
  endtask

  task automatic t_serial_misuse();
    do_reset();
    ser_pop();
    chk("R11 tx pop on empty count", {27'b0, tx_level}, 32'd0);
    chk("R11 no overflow from serial", {31'b0, ovf_flag}, 32'd0);
    chk("R11 no underflow from serial", {31'b0, unf_flag}, 32'd0);
    for (int n = 0; n < 17; n++) ser_push(32'h200 + 32'(n));
    chk("R11 rx full count", {27'b0, rx_level}, 32'd16);
    chk("R11 no flag on rx full push", {31'b0, ovf_flag | unf_flag}, 32'd0);
    for (int n = 0; n < 16; n++) begin
      chk("R1 R11 rx order", host_rx_rdata, 32'h200 + 32'(n));
      host_read();
    end
    chk("R11 extra push dropped", {27'b0, rx_level}, 32'd0);
  endtask

  task automatic t_simultaneous();
    do_reset();
    for (int n = 0; n < 5; n++) host_write(32'h300 + 32'(n), 2'b10);
    @(negedge clk); host_tx_wr = 1'b1; host_tx_wdata = 32'h3FF; host_tx_size = 2'b10; ser_tx_pop = 1'b1;
    @(negedge clk); host_tx_wr = 1'b0; ser_tx_pop = 1'b0;
    chk("R12 count unchanged", {27'b0, tx_level}, 32'd5);
    chk("R12 head advanced", ser_tx_data, 32'h301);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_order_sizes();
    t_tx_codes();
    t_rx_codes();
    t_reserved();
    t_overflow();
    t_underflow();
    t_serial_misuse();
    t_simultaneous();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule